// File: doc/BRIEF.md
# Power-of-Two Clock Divider With Glitch-Free Enable

This block produces a synthesizer output clock by dividing a source clock by 1, 2, 4 or 8, picked by a 2-bit ratio code. It is written as a synchronous model. The source clock is represented by a tick train on `src_tick`. Each tick stands for one source edge, which is one half-period of the source clock. The output is a registered level whose high and low phases are each 2^code ticks long, so every ratio gives a 50% duty cycle.

A free-running phase counter counts ticks. At the tick where the counter wraps from all-ones to zero, every ratio's waveform falls together. The ratio code and the active-high output enable are adopted only at that shared low boundary. As a result, a ratio change or an enable change never creates a short pulse. A divide-by-4 image of the source clock is brought out as a tap for test visibility. It runs whatever the code and enable are.

There is no data stream here, so there is no valid/ready interface. All pins are plain control or clock-level signals.

Top module: `fdiv_top`

## Requirements
- R1: While `rst_n` is low, `fout` and `fdiv4_tap` are 0. The phase count restarts at 0, the adopted code is 00 and the adopted enable is 0.
- R2: The ratio code maps 00 to divide-by-1, 01 to divide-by-2, 10 to divide-by-4 and 11 to divide-by-8. Let n be the number of ticks since reset, modulo 16, and let k be the adopted code. While enabled, `fout` is 1 exactly when bit k of n is 1. High and low phases are therefore each 2^k ticks long (50% duty).
- R3: `fout` and `fdiv4_tap` change only at a clock edge where `src_tick` was 1.
- R4: A new value on `div_code` is adopted only at the wrap tick, which is the tick taken when n is 15. Right after that tick, `fout` and `fdiv4_tap` are both 0.
- R5: `out_en` is adopted only at the wrap tick. While the adopted enable is 0, `fout` stays 0. No high phase is ever shorter or longer than 2^k ticks, and no low phase is shorter than 2^k ticks, across any enable or code toggle.
- R6: `fdiv4_tap` is 1 exactly when bit 2 of n is 1. This makes it a divide-by-4 image of the source clock, independent of `div_code` and `out_en`.
- R7: After enable is adopted, the first `fout` high phase is a full 2^k ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | One pulse per source clock edge (half-period) |
| div_code | input | 2 | Ratio code: 00 /1, 01 /2, 10 /4, 11 /8 |
| out_en | input | 1 | Active-high output enable, adopted at the wrap |
| fout | output | 1 | Divided, gated output clock |
| fdiv4_tap | output | 1 | Divide-by-4 image of the source for test |

## Verification
The assertions assume that `src_tick`, `div_code` and `out_en` are known (0 or 1, never X) at every sampled edge once reset is released. They also assume that reset is held for at least one edge before the block is used. The stimulus drives all inputs away from the active clock edge. It draws ticks at varying densities, including long runs without any tick. It changes the code and the enable on arbitrary cycles, including the wrap tick itself. This places every change somewhere in the phase cycle where the held-until-boundary rule must absorb it.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // default width of the ratio code; the phase counter is 2**width bits
  localparam int unsigned DEF_CODE_W = 2;

  // number of ticks in one half-period for a given ratio code
  function automatic int unsigned half_len(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/fdiv_phase_ctr.sv
module fdiv_phase_ctr #(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] phase_nxt,
  output logic            wrap
);
  // wrap marks the tick that takes every ratio to its common low point
  assign wrap      = tick && (&phase);
  assign phase_nxt = tick ? phase + 1'b1 : phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_nxt;
  end

  // R3: the count only advances on a tick
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
endmodule

// File: rtl/fdiv_cfg_hold.sv
module fdiv_cfg_hold #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [CODE_W-1:0] code_in,
  input  logic              en_in,
  output logic [CODE_W-1:0] code_q,
  output logic              en_q,
  output logic [CODE_W-1:0] code_nxt,
  output logic              en_nxt
);
  assign code_nxt = wrap ? code_in : code_q;
  assign en_nxt   = wrap ? en_in   : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
    end else begin
      code_q <= code_nxt;
      en_q   <= en_nxt;
    end
  end

  // R4: ratio code moves only at the common low boundary
  a_r4_code_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(code_q));
  // R5: enable moves only at the common low boundary
  a_r5_en_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(en_q));
endmodule

// File: rtl/fdiv_out_sel.sv
module fdiv_out_sel #(
  parameter int unsigned CODE_W = 2,
  localparam int unsigned PH_W  = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PH_W-1:0]   phase_nxt,
  input  logic [CODE_W-1:0] code_nxt,
  input  logic              en_nxt,
  output logic              fout
);
  logic [PH_W-1:0] ratio_wave;
  logic            fout_d;

  // one candidate waveform per ratio; ratio k has half-period 2**k ticks
  for (genvar k = 0; k < PH_W; k++) begin : g_ratio
    assign ratio_wave[k] = phase_nxt[k];
  end

  assign fout_d = en_nxt && ratio_wave[code_nxt];

  always_ff @(posedge clk) begin
    if (!rst_n)    fout <= 1'b0;
    else if (tick) fout <= fout_d;
  end

  // R3: output level holds between ticks
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fout));
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
  parameter int unsigned CODE_W  = fdiv_pkg::DEF_CODE_W,
  parameter int unsigned TAP_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic [CODE_W-1:0] div_code,
  input  logic              out_en,
  output logic              fout,
  output logic              fdiv4_tap
);
  localparam int unsigned PH_W = 1 << CODE_W;

  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   phase_nxt;
  logic              wrap;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic              en_q;
  logic              en_nxt;

  fdiv_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(src_tick),
    .phase(phase), .phase_nxt(phase_nxt), .wrap(wrap)
  );

  fdiv_cfg_hold #(.CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wrap(wrap),
    .code_in(div_code), .en_in(out_en),
    .code_q(code_q), .en_q(en_q),
    .code_nxt(code_nxt), .en_nxt(en_nxt)
  );

  fdiv_out_sel #(.CODE_W(CODE_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .tick(src_tick),
    .phase_nxt(phase_nxt), .code_nxt(code_nxt), .en_nxt(en_nxt),
    .fout(fout)
  );

  // R6: divide-by-4 image of the source taken from the free-running count
  assign fdiv4_tap = phase[TAP_IDX];

  // R4: every waveform sits low right after the wrap tick
  a_r4_low_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (!fout && !fdiv4_tap));
  // R5: a disabled output rests low
  a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !fout);
  // R1: reset clears the outputs
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> (!fout && !fdiv4_tap));
endmodule

// File: tb/sim_fdiv_top.sv
module sim_fdiv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_tick = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic       out_en = 1'b0;
  logic       fout;
  logic       fdiv4_tap;

  int unsigned total = 0;
  int unsigned bad   = 0;
  bit          done  = 1'b0;

  // reference state, built from the requirements
  int unsigned n_m = 0;
  int unsigned code_m = 0;
  bit          en_m = 1'b0;
  // phase-length tracking
  bit          lvl_prev = 1'b0;
  int unsigned run_len = 0;
  int unsigned run_code = 0;

  always #2 clk = ~clk;

  fdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .div_code(div_code), .out_en(out_en),
    .fout(fout), .fdiv4_tap(fdiv4_tap)
  );

  function automatic bit exp_out(int unsigned n, int unsigned k, bit en);
    return en && (((n >> k) & 1) == 1);
  endfunction

  function automatic bit exp_tap(int unsigned n);
    return ((n >> 2) & 1) == 1;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive away from the edge, update the reference, then compare
  task automatic step(bit t, logic [1:0] c, bit e);
    bit prev_fout;
    bit prev_tap;
    @(negedge clk);
    prev_fout = fout;
    prev_tap  = fdiv4_tap;
    src_tick = t; div_code = c; out_en = e;
    @(posedge clk);
    #1;
    if (t) begin
      if (n_m == 15) begin
        code_m = c;
        en_m   = e;
      end
      n_m = (n_m + 1) % 16;
    end
    chk("R2", fout, exp_out(n_m, code_m, en_m));
    chk("R6", fdiv4_tap, exp_tap(n_m));
    if (!t) begin
      chk("R3", fout, prev_fout);
      chk("R3", fdiv4_tap, prev_tap);
    end else if (n_m == 0) begin
      chk("R4", fout, 0);
      chk("R4", fdiv4_tap, 0);
    end
    if (!en_m) chk("R5", fout, 0);
    if (t) begin
      if (fout == lvl_prev) run_len++;
      else begin
        if (lvl_prev) chk("R5 high phase", run_len, 32'd1 << run_code);
        else          chk("R7 low before high", run_len >= (32'd1 << code_m), 1);
        lvl_prev = fout;
        run_len  = 1;
        run_code = code_m;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    logic [1:0]  c;
    bit          e;
    seed = 32'd12429;
    void'($urandom(seed));
    // R1: reset state
    repeat (4) @(posedge clk);
    #1;
    chk("R1", fout, 0);
    chk("R1", fdiv4_tap, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: each code enabled for several full cycles, dense ticks
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 64; i++) step(1'b1, 2'(k), 1'b1);
    end
    // directed: disable then re-enable at /8, ticks with gaps
    for (int i = 0; i < 48; i++) step(i % 2 == 0, 2'b11, 1'b0);
    for (int i = 0; i < 64; i++) step(1'b1, 2'b11, 1'b1);
    // R7: first high after enable at /4
    for (int i = 0; i < 32; i++) step(1'b1, 2'b10, 1'b0);
    for (int i = 0; i < 48; i++) step(1'b1, 2'b10, 1'b1);
    // random: code and enable change on arbitrary cycles
    c = 2'b01;
    e = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 23 == 0) c = 2'($urandom % 4);
      if ($urandom % 37 == 0) e = ~e;
      step(($urandom % 4) != 0, c, e);
    end
    // random with long idle stretches
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 11 == 0) c = 2'($urandom % 4);
      if ($urandom % 13 == 0) e = ~e;
      step(($urandom % 9) == 0, c, e);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule